// File: doc/BRIEF.md
# Clock-Stop and Peripheral-Reset Set/Clear Register Bank

This block holds one control bit per peripheral for stopping its clock and one for holding it in reset. Both groups have 64 bits and are split into two 32-bit banks. Software never writes a whole word. Each bank answers at two word addresses. A write to the lower address of the pair turns on every bit that is 1 in the write data. A write to the upper address, four bytes higher, turns off every bit that is 1 in the write data. Bits that are 0 in the write data keep their value. This lets independent drivers each control their own peripheral's bits without a read-modify-write sequence.

Each bit of the banks drives one output line. The reset lines are 1 while a peripheral is held in reset. The clock-stop lines are 1 while a peripheral's clock is stopped. One register bit has the opposite polarity: in that bit a stored 1 means the clock runs. The block flips that bit on the way out, so every clock-stop output line has the same meaning. The register interface is a plain synchronous port: a byte address, a single-cycle write strobe, write data, and read data that follows the address combinationally.

Top module: `ctl_setclr_regs`

## Requirements
- R1: After reset, every reset-group register bit is 1 and every clock-group register bit is 1, except clock bank 0 bit 14, which is 0. A read of offset 0x080 therefore returns 0xFFFFBFFF, and all `periph_rst` and `clk_stop` lines are 1.
- R2: A write to a set offset (0x040, 0x050, 0x080, 0x090) turns on each bit that is 1 in `wdata` and leaves every other bit of that bank unchanged.
- R3: A write to a clear offset (0x044, 0x054, 0x084, 0x094) turns off each bit that is 1 in `wdata` and leaves every other bit of that bank unchanged.
- R4: A read of either address of a pair returns the bank's current register value. The read data follows `addr` in the same cycle.
- R5: Global index i maps to bank i/32 and bit i%32. Offsets 0x040/0x044 hold reset indices 0 to 31 and offsets 0x050/0x054 hold indices 32 to 63. Offsets 0x080/0x084 hold clock indices 0 to 31 and offsets 0x090/0x094 hold indices 32 to 63. Output `periph_rst[i]` equals reset register bit i.
- R6: `clk_stop[i]` is 1 when clock i is stopped. For every index except 14 this equals the register bit. For index 14 a stored 1 means running, so `clk_stop[14]` is the inverse of the register bit.
- R7: A write to any other address, including misaligned or in-between offsets, changes no bit and no output. A read of any other address returns 0.
- R8: A write changes the register and its output lines at the clock edge that samples the strobe. The new value is visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 32 | Write data; each 1 selects a bit to set or clear |
| rdata | output | 32 | Read data for `addr`, zero when unmapped |
| periph_rst | output | 64 | Per-peripheral reset lines, 1 = held in reset |
| clk_stop | output | 64 | Per-peripheral clock-stop lines, 1 = clock stopped |

## Verification
The assertions assume that `wr_en` is a clean one-cycle strobe and that `addr` and `wdata` are stable around the sampling edge. Under those conditions each edge does at most one set, one clear, or nothing to a single bank. The bench drives all inputs on the falling edge, so they are always settled at the rising edge. The random stimulus picks addresses only from the eight mapped offsets plus a fixed list of unmapped and misaligned ones, so it never leaves the address width. The write data is random, so set and clear both hit bits that are already in the target state as well as bits that change.

// File: rtl/ctl_setclr_pkg.sv
package ctl_setclr_pkg;

   // which register group a decoded address belongs to
   typedef enum logic {
      GRP_RST = 1'b0,
      GRP_CLK = 1'b1
   } grp_e;

endpackage

// File: rtl/ctl_setclr_decode.sv
module ctl_setclr_decode
   import ctl_setclr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 2,
   parameter int STRIDE    = 16,
   parameter int RST_BASE  = 'h040,
   parameter int CLK_BASE  = 'h080,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output grp_e              grp,
   output logic [BANK_W-1:0] bank,
   output logic              is_clr
);

   always_comb begin
      hit    = 1'b0;
      grp    = GRP_RST;
      bank   = '0;
      is_clr = 1'b0;
      for (int g = 0; g < 2; g++) begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'((g == 0 ? RST_BASE : CLK_BASE) + b * STRIDE)) begin
               hit    = 1'b1;
               grp    = grp_e'(g[0]);
               bank   = BANK_W'(b);
               is_clr = 1'b0;
            end
            if (addr == ADDR_W'((g == 0 ? RST_BASE : CLK_BASE) + b * STRIDE + 4)) begin
               hit    = 1'b1;
               grp    = grp_e'(g[0]);
               bank   = BANK_W'(b);
               is_clr = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/ctl_setclr_bank.sv
module ctl_setclr_bank #(
   parameter int           W       = 32,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= RST_VAL;
      else if (set_en) q <= q | wdata;
      else if (clr_en) q <= q & ~wdata;
   end

   // R2
   set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((q & $past(wdata)) == $past(wdata)));

   // R2
   set_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

   // R3
   clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));

   // R7
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/ctl_setclr_regs.sv
module ctl_setclr_regs
   import ctl_setclr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 2,
   parameter int STRIDE    = 16,
   parameter int RST_BASE  = 'h040,
   parameter int CLK_BASE  = 'h080,
   parameter int POL_BANK  = 0,
   parameter int POL_BIT   = 14,
   localparam int IDX_N    = NUM_BANKS * DATA_W,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [11:0]       addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [63:0]       periph_rst,
   output logic [63:0]       clk_stop
);

   // elaboration-time parameter checks
   if (ADDR_W != 12 || DATA_W != 32 || IDX_N != 64) begin : g_bad_width
      $error("port widths require ADDR_W=12, DATA_W=32, 64 indices");
   end
   if (STRIDE < 8) begin : g_bad_stride
      $error("STRIDE must leave room for a set/clear pair");
   end
   if (POL_BANK >= NUM_BANKS || POL_BIT >= DATA_W) begin : g_bad_pol
      $error("inverted-polarity bit lies outside the clock banks");
   end
   if (!((CLK_BASE >= RST_BASE + NUM_BANKS * STRIDE) ||
         (RST_BASE >= CLK_BASE + NUM_BANKS * STRIDE))) begin : g_overlap
      $error("reset and clock windows overlap");
   end

   logic              hit;
   grp_e              dgrp;
   logic [BANK_W-1:0] dbank;
   logic              is_clr;

   ctl_setclr_decode #(
      .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .STRIDE(STRIDE),
      .RST_BASE(RST_BASE), .CLK_BASE(CLK_BASE)
   ) u_dec (
      .addr(addr), .hit(hit), .grp(dgrp), .bank(dbank), .is_clr(is_clr)
   );

   logic [DATA_W-1:0] rst_q [NUM_BANKS];
   logic [DATA_W-1:0] clk_q [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam logic [DATA_W-1:0] POL_MASK =
         (b == POL_BANK) ? (DATA_W'(1) << POL_BIT) : '0;

      logic sel_r, sel_c;
      assign sel_r = wr_en && hit && (dgrp == GRP_RST) && (dbank == BANK_W'(b));
      assign sel_c = wr_en && hit && (dgrp == GRP_CLK) && (dbank == BANK_W'(b));

      ctl_setclr_bank #(.W(DATA_W), .RST_VAL('1)) u_rst (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel_r && !is_clr), .clr_en(sel_r && is_clr),
         .wdata(wdata), .q(rst_q[b])
      );

      ctl_setclr_bank #(.W(DATA_W), .RST_VAL(~POL_MASK)) u_clk (
         .clk(clk), .rst_n(rst_n),
         .set_en(sel_c && !is_clr), .clr_en(sel_c && is_clr),
         .wdata(wdata), .q(clk_q[b])
      );

      assign periph_rst[b*DATA_W +: DATA_W] = rst_q[b];
      assign clk_stop[b*DATA_W +: DATA_W]   = clk_q[b] ^ POL_MASK;
   end

   always_comb begin
      rdata = '0;
      if (hit) rdata = (dgrp == GRP_CLK) ? clk_q[dbank] : rst_q[dbank];
   end

   // R7
   unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !hit) |=> ($stable(periph_rst) && $stable(clk_stop)));

   // R8
   rst_grp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit && dgrp == GRP_RST) |=> $stable(clk_stop));

endmodule

// File: tb/ctl_setclr_regs_test.sv
module ctl_setclr_regs_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] addr;
   logic        wr_en;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic [63:0] periph_rst;
   logic [63:0] clk_stop;

   int n_chk  = 0;
   int n_fail = 0;

   logic [63:0] rst_m;
   logic [63:0] clk_m;

   localparam logic [63:0] POL = 64'h1 << 14;

   always #2 clk = ~clk;

   ctl_setclr_regs uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .periph_rst(periph_rst), .clk_stop(clk_stop)
   );

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      case (a)
         12'h040, 12'h044: return rst_m[31:0];
         12'h050, 12'h054: return rst_m[63:32];
         12'h080, 12'h084: return clk_m[31:0];
         12'h090, 12'h094: return clk_m[63:32];
         default:          return 32'h0;
      endcase
   endfunction

   function automatic void model_wr(logic [11:0] a, logic [31:0] d);
      case (a)
         12'h040: rst_m[31:0]  = rst_m[31:0]  | d;
         12'h044: rst_m[31:0]  = rst_m[31:0]  & ~d;
         12'h050: rst_m[63:32] = rst_m[63:32] | d;
         12'h054: rst_m[63:32] = rst_m[63:32] & ~d;
         12'h080: clk_m[31:0]  = clk_m[31:0]  | d;
         12'h084: clk_m[31:0]  = clk_m[31:0]  & ~d;
         12'h090: clk_m[63:32] = clk_m[63:32] | d;
         12'h094: clk_m[63:32] = clk_m[63:32] & ~d;
         default: ;
      endcase
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // writes at the falling edge; the model updates with the sampling edge
   task automatic wr(logic [11:0] a, logic [31:0] d);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(posedge clk);
      model_wr(a, d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [11:0] a);
      addr = a;
      #1;
      check(tag, {32'h0, rdata}, {32'h0, exp_rd(a)});
   endtask

   task automatic check_all(string tag);
      logic [11:0] mapped [8] = '{12'h040, 12'h044, 12'h050, 12'h054,
                                  12'h080, 12'h084, 12'h090, 12'h094};
      foreach (mapped[k]) rd_chk({tag, " R4 readback"}, mapped[k]);
      check({tag, " R5 periph_rst"}, periph_rst, rst_m);
      check({tag, " R6 clk_stop"}, clk_stop, clk_m ^ POL);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [11:0] unm [6] = '{12'h048, 12'h042, 12'h0A0, 12'h000, 12'h098, 12'h081};
      void'($urandom(32'h5eed_0c1c));
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
      rst_m = '1;
      clk_m = ~POL;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 periph_rst after reset", periph_rst, {64{1'b1}});
      check("R1 clk_stop after reset", clk_stop, {64{1'b1}});
      addr = 12'h080; #1;
      check("R1 read 0x080", {32'h0, rdata}, 64'hFFFF_BFFF);
      @(negedge clk);

      // R6 bit 14 polarity: setting it starts the clock
      wr(12'h080, 32'h0000_4000);
      check("R6 clk_stop[14] after set", {63'h0, clk_stop[14]}, 64'h0);
      wr(12'h084, 32'h0000_0001);
      check("R6 clk_stop[0] after clear", {63'h0, clk_stop[0]}, 64'h0);

      // R5 index 40 is bank 1 bit 8
      wr(12'h054, 32'h0000_0100);
      check("R5 periph_rst[40] released", {63'h0, periph_rst[40]}, 64'h0);
      check("R5 other reset lines held", periph_rst | (64'h1 << 40), {64{1'b1}});

      // R3 clear whole bank, R2 partial set
      wr(12'h044, 32'hFFFF_FFFF);
      check("R3 bank cleared", {32'h0, periph_rst[31:0]}, 64'h0);
      wr(12'h040, 32'h0000_00A5);
      check("R2 partial set", {32'h0, periph_rst[31:0]}, 64'hA5);

      // R8 write visible right after its sampling edge
      addr = 12'h090; wdata = 32'h0; wr_en = 1'b1;
      @(posedge clk); #1;
      check("R8 no change on zero-data set", clk_stop, clk_m ^ POL);
      @(negedge clk); wr_en = 1'b0;
      check_all("directed");

      // R7 unmapped accesses
      foreach (unm[k]) begin
         wr(unm[k], 32'hFFFF_FFFF);
         rd_chk("R7 unmapped read zero", unm[k]);
         check("R7 unmapped write periph_rst", periph_rst, rst_m);
         check("R7 unmapped write clk_stop", clk_stop, clk_m ^ POL);
      end

      // random mix of set, clear and unmapped writes
      for (int i = 0; i < 300; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         int sel = $urandom % 10;
         d = $urandom;
         if (sel == 0) a = unm[$urandom % 6];
         else a = 12'h040 + 12'(($urandom % 2) * 12'h040)
                          + 12'(($urandom % 2) * 12'h010)
                          + 12'(($urandom % 2) * 12'h004);
         wr(a, d);
         check("R2 R3 random periph_rst", periph_rst, rst_m);
         check("R6 random clk_stop", clk_stop, clk_m ^ POL);
         if (i % 25 == 0) check_all("random");
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule